// File: doc/BRIEF.md
# Port-Pinned Bus Strobe Decoder

This block turns the CPU's active-low read, write and program-fetch strobes into chip selects and strobes for three devices on one shared 8-bit bus: a small data RAM, the cartridge ROM and the video/audio chip. Devices are picked by dedicated CPU port pins, not by decoding high address bits. One pin selects the RAM, one selects the video chip, and a third, the copy pin, gates writes. When the copy pin is set and both devices are selected, a read pulls data out of the RAM onto the bus and the following write lands in the video chip. That pair of accesses is a fast RAM-to-video transfer.

Each bus cycle is first sorted into one of four access states. IDLE means no strobe is low. READ means only the read strobe is low. WRITE means only the write strobe is low. CLASH means both strobes are low, which is illegal and treated as quiet. Each clock the state is chosen again from the strobes, with no memory between cycles. The routing stage maps the state and the pins to the eight output strobes. It uses a fixed priority: when both devices are selected without the copy pin, the video chip wins the read. A parameter picks what follows the routing stage. With `REG_OUT=1` (the default), a reset-to-inactive register aligns every output to the fabric clock with one cycle of latency. With `REG_OUT=0` a straight combinational path is used. The program-fetch strobe drives the cartridge ROM's output enable and does not depend on the read and write strobes.

Top module: `port_strobe_decoder`

## Requirements
- R1: While `rst_n` is low, all eight outputs read 1 (inactive), whatever the inputs.
- R2: When both `cpu_rd_n` and `cpu_wr_n` are 1 (IDLE), `ram_cs_n`, `ram_oe_n`, `ram_we_n`, `rom_we_n`, `vid_cs_n`, `vid_rd_n` and `vid_wr_n` are all 1.
- R3: In READ or WRITE, `ram_cs_n` equals `ram_sel_n` and `vid_cs_n` equals `vid_sel_n`. In READ with `ram_sel_n`=0 and `vid_sel_n`=1, `ram_oe_n` is 0.
- R4: In READ with `vid_sel_n`=0 and `copy_en`=0, `vid_rd_n` is 0 and `ram_oe_n` is 1, even when `ram_sel_n` is 0 (the video chip has priority).
- R5: In WRITE with `copy_en`=1, `ram_we_n` and `rom_we_n` are 1. In WRITE with `copy_en`=0, `rom_we_n` is 0 and `ram_we_n` equals `ram_sel_n`.
- R6: In WRITE, `vid_wr_n` equals `vid_sel_n`, whatever the value of `copy_en`.
- R7: Copy mode: with `copy_en`=1 and `ram_sel_n`=`vid_sel_n`=0, READ gives `ram_oe_n`=0 and `vid_rd_n`=1, and WRITE gives `vid_wr_n`=0 and `ram_we_n`=1.
- R8: `ram_oe_n` and `vid_rd_n` are never 0 in the same cycle.
- R9: `rom_oe_n` equals `cpu_fetch_n`, whatever the read and write strobes are.
- R10: When `cpu_rd_n` and `cpu_wr_n` are both 0 (CLASH), every output except `rom_oe_n` is 1.
- R11: With `REG_OUT=1`, the outputs show the inputs sampled at the previous rising clock edge. An input change between two edges does not reach the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset; forces all outputs inactive |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_fetch_n | input | 1 | CPU program-fetch strobe, active low |
| vid_sel_n | input | 1 | Port pin selecting the video chip, active low |
| ram_sel_n | input | 1 | Port pin selecting the data RAM, active low |
| copy_en | input | 1 | Port pin that blocks RAM/ROM writes and video reads (copy mode) |
| ram_cs_n | output | 1 | RAM chip select |
| ram_oe_n | output | 1 | RAM read (output enable) strobe |
| ram_we_n | output | 1 | RAM write strobe |
| rom_oe_n | output | 1 | Cartridge ROM output enable |
| rom_we_n | output | 1 | Cartridge write strobe |
| vid_cs_n | output | 1 | Video chip select |
| vid_rd_n | output | 1 | Video chip read strobe |
| vid_wr_n | output | 1 | Video chip write strobe |

## Verification
Two functions can fall in the same cycle. A program fetch can overlap a READ or WRITE decode, and a read with both devices selected can be claimed by either the RAM or the video chip. The bench provokes both by holding `cpu_fetch_n` low during data accesses and by sweeping all 64 combinations of the six inputs, including both-selected reads with and without `copy_en`. A behavioural model with a one-entry queue of expected outputs judges every clock, and the checker confirms that the two read strobes are never low together.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

    // Access state of one bus cycle, chosen from the CPU strobes.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_CLASH = 2'd3
    } acc_e;

    // Output strobe bundle, every field active low.
    typedef struct packed {
        logic ram_cs_n;
        logic ram_oe_n;
        logic ram_we_n;
        logic rom_oe_n;
        logic rom_we_n;
        logic vid_cs_n;
        logic vid_rd_n;
        logic vid_wr_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);
    localparam strobe_t STROBE_QUIET = '1;

endpackage

// File: rtl/sdec_classify.sv
module sdec_classify
    import sdec_pkg::*;
(
    input  logic cpu_rd_n,
    input  logic cpu_wr_n,
    output acc_e acc
);

    always_comb begin
        unique case ({cpu_rd_n, cpu_wr_n})
            2'b11:   acc = ACC_IDLE;
            2'b01:   acc = ACC_READ;
            2'b10:   acc = ACC_WRITE;
            default: acc = ACC_CLASH;
        endcase
    end

endmodule

// File: rtl/sdec_route.sv
module sdec_route
    import sdec_pkg::*;
(
    input  acc_e    acc,
    input  logic    cpu_fetch_n,
    input  logic    vid_sel_n,
    input  logic    ram_sel_n,
    input  logic    copy_en,
    output strobe_t strobes
);

    // Video wins a read when both devices are selected and copy is off.
    logic vid_claims_read;
    assign vid_claims_read = ~vid_sel_n & ~copy_en;

    always_comb begin
        strobes          = STROBE_QUIET;
        strobes.rom_oe_n = cpu_fetch_n;
        unique case (acc)
            ACC_READ: begin
                strobes.ram_cs_n = ram_sel_n;
                strobes.vid_cs_n = vid_sel_n;
                strobes.vid_rd_n = ~vid_claims_read;
                strobes.ram_oe_n = ram_sel_n | vid_claims_read;
            end
            ACC_WRITE: begin
                strobes.ram_cs_n = ram_sel_n;
                strobes.vid_cs_n = vid_sel_n;
                strobes.rom_we_n = copy_en;
                strobes.ram_we_n = ram_sel_n | copy_en;
                strobes.vid_wr_n = vid_sel_n;
            end
            ACC_IDLE, ACC_CLASH: begin
                strobes.ram_cs_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sdec_stage.sv
module sdec_stage
    import sdec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t d,
    output strobe_t q
);

    generate
        if (REG_OUT) begin : g_reg
            strobe_t q_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= STROBE_QUIET;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_comb
            assign q = rst_n ? d : STROBE_QUIET;
        end
    endgenerate

endmodule

// File: rtl/port_strobe_decoder.sv
module port_strobe_decoder
    import sdec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_rd_n,
    input  logic cpu_wr_n,
    input  logic cpu_fetch_n,
    input  logic vid_sel_n,
    input  logic ram_sel_n,
    input  logic copy_en,
    output logic ram_cs_n,
    output logic ram_oe_n,
    output logic ram_we_n,
    output logic rom_oe_n,
    output logic rom_we_n,
    output logic vid_cs_n,
    output logic vid_rd_n,
    output logic vid_wr_n
);

    acc_e    acc;
    strobe_t raw;
    strobe_t outq;

    sdec_classify u_classify (
        .cpu_rd_n (cpu_rd_n),
        .cpu_wr_n (cpu_wr_n),
        .acc      (acc)
    );

    sdec_route u_route (
        .acc         (acc),
        .cpu_fetch_n (cpu_fetch_n),
        .vid_sel_n   (vid_sel_n),
        .ram_sel_n   (ram_sel_n),
        .copy_en     (copy_en),
        .strobes     (raw)
    );

    sdec_stage #(.REG_OUT(REG_OUT)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (outq)
    );

    assign ram_cs_n = outq.ram_cs_n;
    assign ram_oe_n = outq.ram_oe_n;
    assign ram_we_n = outq.ram_we_n;
    assign rom_oe_n = outq.rom_oe_n;
    assign rom_we_n = outq.rom_we_n;
    assign vid_cs_n = outq.vid_cs_n;
    assign vid_rd_n = outq.vid_rd_n;
    assign vid_wr_n = outq.vid_wr_n;

endmodule

// File: rtl/sdec_checker.sv
module sdec_checker #(
    parameter bit REG_OUT = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_rd_n,
    input logic cpu_wr_n,
    input logic cpu_fetch_n,
    input logic vid_sel_n,
    input logic ram_sel_n,
    input logic copy_en,
    input logic ram_cs_n,
    input logic ram_oe_n,
    input logic ram_we_n,
    input logic rom_oe_n,
    input logic rom_we_n,
    input logic vid_cs_n,
    input logic vid_rd_n,
    input logic vid_wr_n
);

    logic quiet_but_rom;
    assign quiet_but_rom = ram_cs_n & ram_oe_n & ram_we_n & rom_we_n
                         & vid_cs_n & vid_rd_n & vid_wr_n;

    // R8: at most one device drives the bus on a read
    a_r8_read_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_oe_n && !vid_rd_n));

    generate
        if (REG_OUT) begin : g_seq
            a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(cpu_rd_n) && $past(cpu_wr_n)) |-> quiet_but_rom);

            a_r10_clash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (!$past(cpu_rd_n) && !$past(cpu_wr_n)) |-> quiet_but_rom);

            a_r9_fetch_follows: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (rom_oe_n == $past(cpu_fetch_n)));

            a_r5_copy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
                $past(copy_en) |-> (ram_we_n && rom_we_n));

            a_r4_video_priority: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(cpu_rd_n) && $past(cpu_wr_n)
                 && !$past(vid_sel_n) && !$past(copy_en))
                |-> (!vid_rd_n && ram_oe_n));
        end else begin : g_comb
            always @(posedge clk) begin
                if (rst_n) begin
                    a_r2_idle_quiet: assert (!(cpu_rd_n && cpu_wr_n) || quiet_but_rom);
                    a_r10_clash_quiet: assert (cpu_rd_n || cpu_wr_n || quiet_but_rom);
                    a_r9_fetch_follows: assert (rom_oe_n == cpu_fetch_n);
                    a_r5_copy_blocks_write: assert (!copy_en || (ram_we_n && rom_we_n));
                    a_r4_video_priority: assert (cpu_rd_n || !cpu_wr_n || vid_sel_n
                        || copy_en || (!vid_rd_n && ram_oe_n));
                end
            end
        end
    endgenerate

endmodule

bind port_strobe_decoder sdec_checker #(.REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_rd_n    (cpu_rd_n),
    .cpu_wr_n    (cpu_wr_n),
    .cpu_fetch_n (cpu_fetch_n),
    .vid_sel_n   (vid_sel_n),
    .ram_sel_n   (ram_sel_n),
    .copy_en     (copy_en),
    .ram_cs_n    (ram_cs_n),
    .ram_oe_n    (ram_oe_n),
    .ram_we_n    (ram_we_n),
    .rom_oe_n    (rom_oe_n),
    .rom_we_n    (rom_we_n),
    .vid_cs_n    (vid_cs_n),
    .vid_rd_n    (vid_rd_n),
    .vid_wr_n    (vid_wr_n)
);

// File: tb/port_strobe_decoder_bench.sv
module port_strobe_decoder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_rd_n = 1'b1, cpu_wr_n = 1'b1, cpu_fetch_n = 1'b1;
    logic vid_sel_n = 1'b1, ram_sel_n = 1'b1, copy_en = 1'b0;
    logic ram_cs_n, ram_oe_n, ram_we_n, rom_oe_n, rom_we_n;
    logic vid_cs_n, vid_rd_n, vid_wr_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] expq[$];
    string      tagq[$];
    logic [7:0] last_val = 8'hFF;

    always #10 clk = ~clk;   // 50 MHz

    port_strobe_decoder u_port_strobe_decoder (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_fetch_n(cpu_fetch_n),
        .vid_sel_n(vid_sel_n), .ram_sel_n(ram_sel_n), .copy_en(copy_en),
        .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .rom_oe_n(rom_oe_n), .rom_we_n(rom_we_n),
        .vid_cs_n(vid_cs_n), .vid_rd_n(vid_rd_n), .vid_wr_n(vid_wr_n)
    );

    // Bench packing: {ram_cs, ram_oe, ram_we, rom_oe, rom_we, vid_cs, vid_rd, vid_wr}
    function automatic logic [7:0] observed();
        return {ram_cs_n, ram_oe_n, ram_we_n, rom_oe_n, rom_we_n,
                vid_cs_n, vid_rd_n, vid_wr_n};
    endfunction

    // Behavioural reference built from the requirements
    function automatic logic [7:0] model(input logic rd, input logic wr,
                                         input logic fe, input logic vs,
                                         input logic rs, input logic cp);
        logic rcs = 1, roe = 1, rwe = 1, mwe = 1, vcs = 1, vrd = 1, vwr = 1;
        bit reading = (rd == 0) && (wr == 1);
        bit writing = (wr == 0) && (rd == 1);
        if (reading || writing) begin
            rcs = rs;
            vcs = vs;
        end
        if (reading) begin
            if (vs == 0 && cp == 0) vrd = 0;
            else if (rs == 0)       roe = 0;
        end
        if (writing) begin
            if (cp == 0) begin
                mwe = 0;
                rwe = rs;
            end
            vwr = vs;
        end
        return {rcs, roe, rwe, fe, mwe, vcs, vrd, vwr};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // One clock: judge the previous cycle, then apply new inputs
    task automatic step(input string tag, input logic rd, input logic wr,
                        input logic fe, input logic vs, input logic rs, input logic cp);
        @(negedge clk);
        if (expq.size() > 0) begin
            last_val = expq.pop_front();
            check(tagq.pop_front(), observed(), last_val);
        end
        cpu_rd_n = rd; cpu_wr_n = wr; cpu_fetch_n = fe;
        vid_sel_n = vs; ram_sel_n = rs; copy_en = cp;
        #2;
        check({tag, " R11 hold"}, observed(), last_val);
        expq.push_back(model(rd, wr, fe, vs, rs, cp));
        tagq.push_back(tag);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything inactive despite active inputs
        cpu_rd_n = 0; ram_sel_n = 0; vid_sel_n = 0; cpu_fetch_n = 0;
        repeat (3) begin
            @(negedge clk);
            check("R1 reset", observed(), 8'hFF);
        end
        @(negedge clk);
        cpu_rd_n = 1; ram_sel_n = 1; vid_sel_n = 1; cpu_fetch_n = 1;
        rst_n = 1;

        // args: rd, wr, fetch, vid_sel, ram_sel, copy
        step("R2 idle",          1, 1, 1, 0, 0, 0);
        step("R2 idle copy",     1, 1, 1, 0, 0, 1);
        step("R3 ram read",      0, 1, 1, 1, 0, 0);
        step("R3 ram write",     1, 0, 1, 1, 0, 0);
        step("R4 video read",    0, 1, 1, 0, 1, 0);
        step("R4 video priority",0, 1, 1, 0, 0, 0);
        step("R5 write blocked", 1, 0, 1, 1, 0, 1);
        step("R5 write open",    1, 0, 1, 1, 1, 0);
        step("R6 video write",   1, 0, 1, 0, 1, 0);
        step("R6 video write cp",1, 0, 1, 0, 1, 1);
        step("R7 copy read",     0, 1, 1, 0, 0, 1);
        step("R7 copy write",    1, 0, 1, 0, 0, 1);
        step("R9 fetch idle",    1, 1, 0, 1, 1, 0);
        step("R9 fetch on read", 0, 1, 0, 0, 0, 0);
        step("R9 fetch on write",1, 0, 0, 0, 0, 0);
        step("R10 clash",        0, 0, 1, 0, 0, 0);
        step("R10 clash fetch",  0, 0, 0, 0, 0, 1);
        step("R2 back to idle",  1, 1, 1, 1, 1, 0);

        // R8: full sweep of all input combinations
        for (int k = 0; k < 64; k++) begin
            logic [5:0] v = 6'(k);
            step("R8 sweep", v[5], v[4], v[3], v[2], v[1], v[0]);
        end
        step("R2 flush", 1, 1, 1, 1, 1, 0);
        @(negedge clk);
        while (expq.size() > 0) begin
            last_val = expq.pop_front();
            check(tagq.pop_front(), observed(), last_val);
        end

        // R1: reset asserted mid-run returns outputs to inactive
        cpu_rd_n = 0; ram_sel_n = 0;
        rst_n = 0;
        #2;
        check("R1 reset mid-run", observed(), 8'hFF);

        done = 1'b1;
        report();
        $finish;
    end

endmodule